// File: doc/BRIEF.md
# Predicated Multi-Vector Store Sequencer

This block breaks one contiguous store of two or four consecutive vector registers into single-doubleword write requests. A one-cycle start pulse supplies the operands: a 64-bit base address, a signed 4-bit immediate, the register-count select, the encoded first-register field and an activity mask with one bit per byte lane. The block scales the immediate by the register count and the vector length to get the starting address. It then fetches each source register through a simple read port and issues one write per active 64-bit element.

The block visits registers in ascending order and, within each register, elements in ascending order. The address grows by 8 bytes for every element, whether the element is written or not, and wraps modulo 2^64. A write request stays unchanged until the downstream side accepts it. The block raises an alignment-check request when the base comes from the stack pointer. It signals completion with a one-cycle done pulse.

Top module: `vec_store_seq`

## Requirements
- R1: The first element address is `base_addr + sext(imm4) * N * (VLEN/8)` modulo 2^64. N is 2 when `four_regs`=0 and 4 when `four_regs`=1.
- R2: The first source register index is `reg_field*2` in the 2-register form and `reg_field[2:0]*4` in the 4-register form. The following registers are the next consecutive indices, wrapping modulo 32.
- R3: Elements are visited with registers outer (0 to N-1) and elements inner (0 to VLEN/64-1). The address grows by 8 for every element, active or inactive.
- R4: Let k = r*(VLEN/64)+e. Element e of register r is active when `mask[8*k]` is 1. Only active elements produce a write request.
- R5: The write data of element e is bits [64e+63:64e] of the source register data returned on `rd_data` for `rd_idx`.
- R6: While `wr_valid` is high and `wr_ready` is low, the next cycle keeps `wr_valid` high with the same `wr_addr` and `wr_data`.
- R7: `done` is high for exactly one cycle, the cycle after the last element is processed. This holds even when no element is active. No request is issued once the operation ends.
- R8: A start pulse that arrives while an operation is in progress is ignored.
- R9: `align_chk` pulses in the cycle after an accepted start when `base_is_sp` is 1 and at least one element is active. With no active element, it pulses only if parameter `SP_CHECK_IDLE` is 1 (default 0).
- R10: After reset, `wr_valid`, `done` and `align_chk` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle operation start |
| base_addr | input | 64 | Scalar base address |
| base_is_sp | input | 1 | Base taken from stack pointer |
| imm4 | input | 4 | Signed immediate, in units of N vectors |
| four_regs | input | 1 | 1 selects four registers, 0 selects two |
| reg_field | input | 4 | Encoded first-register field |
| mask | input | VLEN/2 | Per-byte-lane activity bits, all four registers |
| rd_idx | output | 5 | Source register read index |
| rd_data | input | VLEN | Source register read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 64 | Write byte address |
| wr_data | output | 64 | Write doubleword |
| done | output | 1 | Completion pulse |
| align_chk | output | 1 | Stack-pointer alignment-check request |

## Verification
The assertions check on every cycle that a stalled request is held, that done is a single pulse outside an active operation, that no request appears when idle, that a new accepted request always carries a new address, and that align_chk follows only an accepted start. Only the bench scenarios can show the exact address arithmetic, including negative immediates and wrap-around. The same holds for register selection, the skipping of inactive elements in the alternating and all-inactive masks, the per-element data selection, and the rejection of a start that arrives mid-operation.

// File: rtl/vec_store_seq.sv
module vec_store_seq #(
  parameter int VLEN = 256,
  parameter bit SP_CHECK_IDLE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [63:0]           base_addr,
  input  logic                  base_is_sp,
  input  logic [3:0]            imm4,
  input  logic                  four_regs,
  input  logic [3:0]            reg_field,
  input  logic [VLEN/2-1:0]     mask,
  output logic [4:0]            rd_idx,
  input  logic [VLEN-1:0]       rd_data,
  output logic                  wr_valid,
  input  logic                  wr_ready,
  output logic [63:0]           wr_addr,
  output logic [63:0]           wr_data,
  output logic                  done,
  output logic                  align_chk
);
  localparam int ELEMS = VLEN / 64;
  localparam int LANES = VLEN / 8;
  localparam int MASKW = 4 * LANES;
  localparam int EW    = (ELEMS > 1) ? $clog2(ELEMS) : 1;
  localparam int KW    = $clog2(4 * ELEMS);

  logic             busy, four_q;
  logic [4:0]       first_q;
  logic [1:0]       r_q;
  logic [EW-1:0]    e_q;
  logic [KW-1:0]    k_q;
  logic [63:0]      addr_q;
  logic [MASKW-1:0] mask_q;

  logic [63:0] start_off;
  logic        any_act, act, adv, r_last, e_last;

  assign start_off = {{60{imm4[3]}}, imm4} * (four_regs ? 64'(4 * LANES) : 64'(2 * LANES));

  always_comb begin
    any_act = 1'b0;
    for (int k = 0; k < 4 * ELEMS; k++)
      if (k < (four_regs ? 4 : 2) * ELEMS && mask[8*k]) any_act = 1'b1;
  end

  assign act    = mask_q[8*k_q];
  assign r_last = four_q ? (r_q == 2'd3) : (r_q == 2'd1);
  assign e_last = (e_q == EW'(ELEMS - 1));
  assign adv    = busy && (!act || wr_ready);

  assign rd_idx   = first_q + {3'b000, r_q};
  assign wr_valid = busy && act;
  assign wr_addr  = addr_q;
  assign wr_data  = 64'(rd_data >> {e_q, 6'd0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      four_q    <= 1'b0;
      first_q   <= '0;
      r_q       <= '0;
      e_q       <= '0;
      k_q       <= '0;
      addr_q    <= '0;
      mask_q    <= '0;
      done      <= 1'b0;
      align_chk <= 1'b0;
    end else begin
      done      <= 1'b0;
      align_chk <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          four_q    <= four_regs;
          first_q   <= four_regs ? {reg_field[2:0], 2'b00} : {reg_field, 1'b0};
          r_q       <= '0;
          e_q       <= '0;
          k_q       <= '0;
          addr_q    <= base_addr + start_off;
          mask_q    <= mask;
          align_chk <= base_is_sp && (any_act || SP_CHECK_IDLE);
        end
      end else if (adv) begin
        addr_q <= addr_q + 64'd8;
        k_q    <= k_q + 1'b1;
        if (e_last) begin
          e_q <= '0;
          r_q <= r_q + 2'd1;
          if (r_last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          e_q <= e_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vec_store_seq_chk.sv
module vec_store_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [63:0] wr_addr,
  input logic [63:0] wr_data,
  input logic        done,
  input logic        align_chk
);
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R6
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid); // R7
  AST_NEW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !wr_valid || (wr_addr != $past(wr_addr))); // R3
  AST_ALIGN_START: assert property (@(posedge clk) disable iff (!rst_n)
    align_chk |-> $past(start) && !$past(busy)); // R9
endmodule

bind vec_store_seq vec_store_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .done(done), .align_chk(align_chk)
);

// File: tb/vec_store_seq_tb_top.sv
`timescale 1ns/1ps
module vec_store_seq_tb_top;
  localparam int VLEN  = 256;
  localparam int ELEMS = VLEN / 64;
  localparam int LANES = VLEN / 8;
  localparam int MASKW = 4 * LANES;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0] base_addr = '0;
  logic base_is_sp = 1'b0, four_regs = 1'b0, wr_ready = 1'b1;
  logic [3:0] imm4 = '0, reg_field = '0;
  logic [MASKW-1:0] mask = '0;
  logic [4:0] rd_idx;
  logic [VLEN-1:0] rd_data;
  logic wr_valid, done, align_chk;
  logic [63:0] wr_addr, wr_data;

  logic [VLEN-1:0] regs [32];
  assign rd_data = regs[rd_idx];

  vec_store_seq #(.VLEN(VLEN), .SP_CHECK_IDLE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .base_is_sp(base_is_sp), .imm4(imm4), .four_regs(four_regs),
    .reg_field(reg_field), .mask(mask), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .align_chk(align_chk));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int stall_mode = 0;
  logic [63:0] exp_addr [64];
  logic [63:0] exp_data [64];
  int exp_n = 0, got_n = 0, done_cnt = 0, align_cnt = 0;
  bit held = 1'b0;
  logic [63:0] held_addr, held_data;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    #1;
    case (stall_mode)
      0: wr_ready = 1'b1;
      1: wr_ready = (cycles % 3) != 0;
      default: wr_ready = (cycles % 4) == 0;
    endcase
  end

  always @(negedge clk) if (rst_n) begin
    if (held) begin
      check(wr_valid && wr_addr == held_addr && wr_data == held_data, "R6",
            "stalled request held", wr_addr, held_addr);
      held = 1'b0;
    end
    if (wr_valid && !wr_ready) begin
      held = 1'b1; held_addr = wr_addr; held_data = wr_data;
    end
    if (wr_valid && wr_ready) begin
      if (got_n < exp_n) begin
        check(wr_addr == exp_addr[got_n], "R1/R3", "write address", wr_addr, exp_addr[got_n]);
        check(wr_data == exp_data[got_n], "R4/R5", "write data", wr_data, exp_data[got_n]);
      end else begin
        check(1'b0, "R4", "unexpected write", wr_addr, 64'd0);
      end
      got_n++;
    end
    if (done) done_cnt++;
    if (align_chk) align_cnt++;
  end

  function automatic logic [63:0] elem_val(input int r, input int e);
    return {8'hA5, 8'(r), 8'(e), 8'h3C, 32'(r * 7919 + e * 104729)};
  endfunction

  task automatic build_expect(input logic [63:0] base, input logic [3:0] imm, input bit four,
                              input logic [3:0] field, input logic [MASKW-1:0] m);
    int n = four ? 4 : 2;
    int first = four ? int'(field[2:0]) * 4 : int'(field) * 2;
    logic [63:0] a = base + 64'($signed(imm) * n * LANES);
    exp_n = 0;
    for (int r = 0; r < n; r++)
      for (int e = 0; e < ELEMS; e++) begin
        if (m[8*(r*ELEMS+e)]) begin
          exp_addr[exp_n] = a;
          exp_data[exp_n] = elem_val((first + r) % 32, e);
          exp_n++;
        end
        a = a + 64'd8;
      end
  endtask

  task automatic run_case(input string name, input logic [63:0] base, input bit sp,
                          input logic [3:0] imm, input bit four, input logic [3:0] field,
                          input logic [MASKW-1:0] m, input int stalls, input bit exp_align,
                          input bit retrigger);
    int wait_c = 0;
    build_expect(base, imm, four, field, m);
    got_n = 0; done_cnt = 0; align_cnt = 0; stall_mode = stalls;
    @(negedge clk);
    base_addr = base; base_is_sp = sp; imm4 = imm; four_regs = four;
    reg_field = field; mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (retrigger) begin
      @(negedge clk);
      base_addr = base ^ 64'hFFFF_0000; base_is_sp = 1'b1; imm4 = 4'd3;
      reg_field = field + 4'd1; mask = '1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == 0 && wait_c < 1000) begin @(negedge clk); wait_c++; end
    repeat (3) @(negedge clk);
    check(done_cnt == 1, "R7", {name, " done pulse count"}, 64'(done_cnt), 64'd1);
    check(got_n == exp_n, retrigger ? "R8" : "R4", {name, " write count"}, 64'(got_n), 64'(exp_n));
    check(align_cnt == int'(exp_align), "R9", {name, " align request"}, 64'(align_cnt), 64'(exp_align));
    check(!wr_valid, "R7", {name, " idle after done"}, 64'(wr_valid), 64'd0);
  endtask

  localparam logic [MASKW-1:0] ALL_ON = {MASKW{1'b1}};

  function automatic logic [MASKW-1:0] alt_mask(input int phase);
    logic [MASKW-1:0] m = '0;
    for (int k = 0; k < 4 * ELEMS; k++)
      if ((k % 2) == phase) m[8*k +: 8] = 8'hFF;
    return m;
  endfunction

  initial begin
    for (int r = 0; r < 32; r++)
      for (int e = 0; e < ELEMS; e++) regs[r][64*e +: 64] = elem_val(r, e);
    repeat (3) @(negedge clk);
    check(!wr_valid && !done && !align_chk, "R10", "reset outputs",
          {61'd0, wr_valid, done, align_chk}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 R3 R5: two registers (6,7), zero offset, all active
    run_case("basic2", 64'h0000_1000_0000_0008, 1'b0, 4'd0, 1'b0, 4'd3, ALL_ON, 0, 1'b0, 1'b0);
    // R1 R4 R6: offset -16 vectors, alternating mask, stalls
    run_case("neg16", 64'h0000_0000_0004_0000, 1'b0, 4'h8, 1'b0, 4'd15, alt_mask(0), 1, 1'b0, 1'b0);
    // R1 R2: four registers 28..31, offset -32 vectors, address wraps below zero
    run_case("neg32wrap", 64'h0000_0000_0000_0100, 1'b0, 4'h8, 1'b1, 4'd7, alt_mask(1), 2, 1'b0, 1'b0);
    // R7 R9: stack pointer base, nothing active
    run_case("allidle", 64'h0000_7FFF_FFF0_0000, 1'b1, 4'd2, 1'b1, 4'd1, '0, 0, 1'b0, 1'b0);
    // R9: stack pointer base with one active element in last register
    run_case("spactive", 64'h0000_7FFF_FFF0_0000, 1'b1, 4'd1, 1'b1, 4'd2,
             MASKW'(1) << (8 * (4 * ELEMS - 1)), 1, 1'b1, 1'b0);
    // R8: start while busy is ignored
    run_case("retrig", 64'h0000_0000_00AB_0000, 1'b0, 4'd7, 1'b1, 4'd4, ALL_ON, 2, 1'b0, 1'b1);
    // R2: 2-register form with lanes above 2*ELEMS set must ignore them
    run_case("upper", 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 4'd1, 1'b0, 4'd9, ALL_ON, 1, 1'b0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule